// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block gates two groups of clock outputs under control of two active-low stop requests that arrive with no timing relation to any clock. A processor group has a single output, and a bus group has six outputs that always move together. A low level on a group's stop input parks that group's outputs at logic low. A high level lets the group run again. A memory reference clock passes through untouched. A stop request never affects a group it does not control.

Each stop request first passes through a two-flop synchronizer clocked by the processor clock, because all stop latency is counted against that clock. Each group then has a two-state controller whose state register is clocked on the falling edge of the group's own source clock. Its states are RUN and PARK. The transition PARK_ENTER (RUN to PARK) is taken when the synchronized request says stop. The transition PARK_EXIT (PARK to RUN) is taken when the request says run. Every output is its source clock ANDed with an enable decoded from the state. The enable changes only at a falling edge, while the source is low. As a result, the block cannot produce a shortened high pulse, and a stopped output always rests low.

The bus clock is assumed to be derived from the processor clock at half its frequency. Its rising edges fall on falling edges of the processor clock.

Top module: `clk_stop_gate`

## Requirements
- R1: A stop input level reaches a group's controller only after two consecutive rising edges of the processor clock have sampled it. Stop inputs must be held for at least two processor cycles.
- R2: A parked output is logic low throughout both phases of its source clock.
- R3: Every high pulse on a gated output lasts a full half-period of its source clock: 2 ns for the processor group and 4 ns for the bus group.
- R4: If processor stop goes low during a low phase of the processor clock, exactly 2 more full processor pulses appear before the output parks. If it goes high, exactly 2 source rising edges are suppressed before pulses resume. Both latencies are fewer than 4 cycles.
- R5: If bus stop goes low, exactly 1 more full bus pulse appears before the bus outputs park. If it goes high, exactly 1 bus rising edge is suppressed before pulses resume.
- R6: A stop request on one group does not change the pulse count of the other group. The reference output follows the reference input at every edge.
- R7: All six bus outputs carry the same level at every instant.
- R8: While rst_n is low, both groups run whatever their stop inputs are. After rst_n is released with a stop input low, that group parks with the latency of R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; forces both groups to run |
| proc_clk | input | 1 | Processor source clock; also clocks both synchronizers |
| bus_clk | input | 1 | Bus source clock, half the processor frequency |
| ref_clk | input | 1 | Memory reference clock, passed through |
| proc_stop_n | input | 1 | Asynchronous active-low stop request for the processor group |
| bus_stop_n | input | 1 | Asynchronous active-low stop request for the bus group |
| proc_clk_out | output | 1 | Gated processor clock |
| bus_clk_out | output | 6 | Gated bus clocks |
| ref_clk_out | output | 1 | Reference clock output |

## Verification
If a controller holds the wrong state, the effect shows at the outputs within one source period. Either a pulse appears that should have been parked, or an expected pulse is missing. The counts of pulses in a fixed window therefore differ from the latency-derived figures of 2, 14 or 16 processor pulses and 1, 7 or 8 bus pulses. If the enable changes at the wrong edge, the next high pulse comes out short, and the per-pulse width measurement catches it. A synchronizer of the wrong depth shifts the stop and restart counts by one pulse.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

    // Two-state controller of one gated clock group.
    typedef enum logic {
        LANE_RUN  = 1'b0,
        LANE_PARK = 1'b1
    } lane_state_e;

endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic run_req
);

    localparam int CNT_W = $clog2(STAGES + 1);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(STAGES);

    logic [STAGES-1:0] chain_q;

    // Reset loads ones: the group runs until a stop is seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], req_n_async};
    end

    assign run_req = chain_q[STAGES-1];

    // Checker state: consecutive samples of each input level.
    logic [CNT_W-1:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= req_n_async ? '0 : ((lo_cnt == SAT) ? SAT : lo_cnt + 1'b1);
            hi_cnt <= req_n_async ? ((hi_cnt == SAT) ? SAT : hi_cnt + 1'b1) : '0;
        end
    end

    // R1: a stop only appears after STAGES low samples of the input.
    assert_stop_synced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_req) |-> (lo_cnt >= SAT));

    // R1: a release only appears after STAGES high samples of the input.
    assert_release_synced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req) |-> (hi_cnt >= SAT));

endmodule

// File: rtl/gate_lane.sv
module gate_lane
    import clk_gate_pkg::*;
#(
    parameter int NUM_OUT = 1
) (
    input  logic               gclk,
    input  logic               rst_n,
    input  logic               run_req,
    output logic [NUM_OUT-1:0] gclk_out
);

    lane_state_e state_q, state_d;
    logic        en;

    // Next state: PARK_ENTER on a stop request, PARK_EXIT on release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_RUN:  if (!run_req) state_d = LANE_PARK;
            LANE_PARK: if (run_req)  state_d = LANE_RUN;
        endcase
    end

    // State register on the falling edge: enable moves only while gclk is low.
    always_ff @(negedge gclk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_RUN;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        en = (state_q == LANE_RUN);
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign gclk_out[i] = gclk & en;
    end

    // R2: a stop seen at the previous falling edge leaves this high phase dark.
    assert_parked_low_R2: assert property (@(negedge gclk) disable iff (!rst_n)
        !$past(run_req) |-> (gclk_out == '0));

    // R3: a run seen at the previous falling edge gives a full high phase on all outputs.
    assert_full_pulse_R3: assert property (@(negedge gclk) disable iff (!rst_n)
        $past(run_req) |-> (gclk_out == '1));

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int BUS_OUTS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                rst_n,
    input  logic                proc_clk,
    input  logic                bus_clk,
    input  logic                ref_clk,
    input  logic                proc_stop_n,
    input  logic                bus_stop_n,
    output logic                proc_clk_out,
    output logic [BUS_OUTS-1:0] bus_clk_out,
    output logic                ref_clk_out
);

    logic proc_run, bus_run;
    logic [0:0] proc_vec;

    // Both requests are timed against the processor clock.
    stop_sync #(.STAGES(SYNC_STAGES)) u_proc_sync (
        .clk         (proc_clk),
        .rst_n       (rst_n),
        .req_n_async (proc_stop_n),
        .run_req     (proc_run)
    );

    stop_sync #(.STAGES(SYNC_STAGES)) u_bus_sync (
        .clk         (proc_clk),
        .rst_n       (rst_n),
        .req_n_async (bus_stop_n),
        .run_req     (bus_run)
    );

    gate_lane #(.NUM_OUT(1)) u_proc_lane (
        .gclk     (proc_clk),
        .rst_n    (rst_n),
        .run_req  (proc_run),
        .gclk_out (proc_vec)
    );

    gate_lane #(.NUM_OUT(BUS_OUTS)) u_bus_lane (
        .gclk     (bus_clk),
        .rst_n    (rst_n),
        .run_req  (bus_run),
        .gclk_out (bus_clk_out)
    );

    assign proc_clk_out = proc_vec[0];
    assign ref_clk_out  = ref_clk;

endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/100ps
module test_clk_stop_gate;

    localparam int BUS_OUTS = 6;
    localparam int WIN_P    = 16;   // processor cycles per window
    localparam int WIN_B    = 8;    // bus cycles per window
    localparam int LAT_P    = 2;    // R4 latency in pulses
    localparam int LAT_B    = 1;    // R5 latency in pulses
    localparam int NVEC     = 10;
    // {proc_stop_n, bus_stop_n} per window
    localparam logic [1:0] VEC [0:NVEC-1] = '{2'b11, 2'b01, 2'b00, 2'b10, 2'b11,
                                              2'b00, 2'b11, 2'b10, 2'b01, 2'b11};

    logic rst_n = 1'b0;
    logic proc_clk = 1'b0, bus_clk = 1'b0, ref_clk = 1'b0;
    logic proc_stop_n = 1'b0, bus_stop_n = 1'b0;
    logic proc_clk_out, ref_clk_out;
    logic [BUS_OUTS-1:0] bus_clk_out;

    int checks = 0, failures = 0;
    int p_cnt = 0, b_cnt = 0, r_cnt = 0;
    bit done = 1'b0;

    always #2 proc_clk = ~proc_clk;     // 250 MHz
    always #4 bus_clk  = ~bus_clk;
    initial begin #0.5; forever #2 ref_clk = ~ref_clk; end

    clk_stop_gate #(.BUS_OUTS(BUS_OUTS), .SYNC_STAGES(2)) i_clk_stop_gate (
        .rst_n, .proc_clk, .bus_clk, .ref_clk, .proc_stop_n, .bus_stop_n,
        .proc_clk_out, .bus_clk_out, .ref_clk_out
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge proc_clk_out)  p_cnt++;
    always @(posedge bus_clk_out[0]) b_cnt++;
    always @(posedge ref_clk_out)   r_cnt++;

    // R3: pulse width of every gated output
    realtime p_rise = -1.0;
    always @(posedge proc_clk_out) p_rise = $realtime;
    always @(negedge proc_clk_out) if (p_rise >= 0.0)
        check_eq("R3 proc pulse width x10ns", int'(($realtime - p_rise) * 10.0), 20);

    for (genvar g = 0; g < BUS_OUTS; g++) begin : g_bw
        realtime b_rise = -1.0;
        always @(posedge bus_clk_out[g]) b_rise = $realtime;
        always @(negedge bus_clk_out[g]) if (b_rise >= 0.0)
            check_eq("R3 bus pulse width x10ns", int'(($realtime - b_rise) * 10.0), 40);
    end

    // R6: reference output tracks its input
    always @(ref_clk) begin
        #0.1;
        check_eq("R6 ref follows input", int'(ref_clk_out), int'(ref_clk));
    end

    function automatic int exp_pulses(input bit prev_run, input bit cur_run,
                                      input int win, input int lat);
        if (prev_run && cur_run)  return win;
        if (prev_run && !cur_run) return lat;
        if (!prev_run && cur_run) return win - lat;
        return 0;
    endfunction

    // Window starts at a time of 1 mod 8 ns: both source clocks low.
    task automatic run_window(input bit ps, input bit bs, input bit pp, input bit pb,
                              input string label);
        proc_stop_n = ps;
        bus_stop_n  = bs;
        p_cnt = 0; b_cnt = 0; r_cnt = 0;
        #64;
        check_eq({"R1/R4/R6 proc pulses ", label}, p_cnt, exp_pulses(pp, ps, WIN_P, LAT_P));
        check_eq({"R5/R6 bus pulses ", label}, b_cnt, exp_pulses(pb, bs, WIN_B, LAT_B));
        check_eq({"R6 ref pulses ", label}, r_cnt, WIN_P);
        #2;   // processor clock high
        check_eq({"R2 proc level ", label}, int'(proc_clk_out), int'(ps));
        #2;   // bus clock high
        check_eq({"R2/R7 bus level ", label}, int'(bus_clk_out), bs ? 63 : 0);
        #4;
    endtask

    initial begin
        #33;
        // R8: reset holds both groups running though stops are low
        p_cnt = 0; b_cnt = 0; r_cnt = 0;
        #64;
        check_eq("R8 proc runs in reset", p_cnt, WIN_P);
        check_eq("R8 bus runs in reset", b_cnt, WIN_B);
        // R8: release with stops low; groups park with R4/R5 latency
        rst_n = 1'b1;
        p_cnt = 0; b_cnt = 0;
        #64;
        check_eq("R8/R4 proc park after release", p_cnt, LAT_P);
        check_eq("R8/R5 bus park after release", b_cnt, LAT_B);
        #8;
        begin
            bit pp = 1'b0, pb = 1'b0;
            for (int i = 0; i < NVEC; i++) begin
                run_window(VEC[i][1], VEC[i][0], pp, pb, $sformatf("vec%0d", i));
                pp = VEC[i][1];
                pb = VEC[i][0];
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule